// File: doc/BRIEF.md
# Serial Programming Command Front End

This block sits on the target side of a two-wire serial programming link used while a device is held in program/verify mode. A host toggles a serial clock and a bidirectional data line. The block oversamples both wires with the system clock and assembles six-bit opcodes, sent least significant bit first. Each recognised opcode becomes a one-cycle strobe for the memory controller behind it. Unrecognised opcodes are discarded.

Three opcodes carry a sixteen-clock payload: one start bit, fourteen data bits sent least significant bit first, and one stop bit. For the two load opcodes, the block collects the fourteen-bit word and hands it to the controller with a valid pulse. For the read opcode, the command strobe also serves as the read request. The block then returns the controller's word on the shared data line and turns the line's output enable on and off at the points the protocol sets.

The block also enforces a minimum gap, counted in system-clock cycles, between a payload command and the first clock of its payload. A payload clock that arrives too early raises an error pulse.

Top module: `pgm_cmd_frontend`

## Requirements
- R1: Six bits sampled on six serial-clock falling edges form an opcode, with the first bit as bit 0. For the defined opcodes (hex 00, 02, 04, 06, 08, 09, 0A, 11, 16, 18), `cmd_stb` pulses for exactly one system cycle and `cmd_op` carries the opcode.
- R2: Any other opcode produces no strobe and opens no payload phase, so the next six serial clocks are decoded as a new command.
- R3: After opcode 00 or 02, sixteen payload clocks are taken. Bits sampled on falling edges 2 to 15 form `wr_data` bits 0 to 13. One `wr_valid` pulse follows the sixteenth falling edge.
- R4: After opcode 04, `rd_data` is captured at the first payload falling edge. It must be valid by then, since the strobe at decode acts as the request.
- R5: `sdat_oe` is low outside a read payload. It rises after the first falling edge of a read payload and falls after the sixteenth.
- R6: During a read payload, `sdat_o` holds 0 as the start bit, then presents data bit k-2 after rising edge k for k = 2..15, then holds 0 after rising edge 16.
- R7: A payload rising edge seen fewer than `DLY_CYCLES` system cycles after a payload command is decoded gives a one-cycle `proto_err` pulse. The payload is still framed normally.
- R8: Opcodes without a payload (06, 08, 09, 0A, 11, 16, 18) return the block straight to command reception.
- R9: After reset all outputs are low and the block waits for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| sdat_i | input | 1 | Serial data from the host |
| sdat_o | output | 1 | Serial data to the host |
| sdat_oe | output | 1 | Output enable for the data pad |
| cmd_stb | output | 1 | One-cycle strobe for a decoded command |
| cmd_op | output | 6 | Opcode that goes with the strobe |
| rd_data | input | 14 | Word from the controller for a read |
| wr_valid | output | 1 | One-cycle strobe for a received word |
| wr_data | output | 14 | Received payload word |
| proto_err | output | 1 | Pulse for a payload clock that came too early |

## Verification
A corrupted bit counter or phase flag shows up one command later. Every following opcode decodes wrongly, so the strobe carries the wrong code or no strobe appears within six serial clocks. That is why the opcode sweep runs back to back with no resets in between. A wrong read shift or enable point shows as a bad data bit or a misplaced enable in the same payload. These are sampled just before each serial falling edge, where the host would latch them.

// File: rtl/pgm_cmd_frontend.sv
module pgm_cmd_frontend #(
  parameter int DLY_CYCLES = 16,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_i,
  input  logic        sdat_i,
  output logic        sdat_o,
  output logic        sdat_oe,
  output logic        cmd_stb,
  output logic [5:0]  cmd_op,
  input  logic [13:0] rd_data,
  output logic        wr_valid,
  output logic [13:0] wr_data,
  output logic        proto_err
);
  localparam int DW = $clog2(DLY_CYCLES + 1);

  logic [SYNC-1:0] ck_sync, dt_sync;
  logic            ck_prev;
  logic            in_pay, pay_rd;
  logic [3:0]      cnt;
  logic [15:0]     sh;
  logic [DW-1:0]   dly;

  wire ck   = ck_sync[SYNC-1];
  wire dt   = dt_sync[SYNC-1];
  wire rise = ck & ~ck_prev;
  wire fall = ~ck & ck_prev;
  wire [5:0] op_nxt = {dt, sh[15:11]};

  logic op_def, op_pay;
  always_comb begin
    op_def = 1'b0;
    op_pay = 1'b0;
    case (op_nxt)
      6'h00, 6'h02, 6'h04: begin op_def = 1'b1; op_pay = 1'b1; end
      6'h06, 6'h16, 6'h08, 6'h18, 6'h0A, 6'h09, 6'h11: op_def = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sync <= '0; dt_sync <= '0; ck_prev <= 1'b0;
    end else begin
      ck_sync <= {ck_sync[SYNC-2:0], sclk_i};
      dt_sync <= {dt_sync[SYNC-2:0], sdat_i};
      ck_prev <= ck;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pay <= 1'b0; pay_rd <= 1'b0; cnt <= '0; sh <= '0; dly <= '0;
      sdat_o <= 1'b0; sdat_oe <= 1'b0; cmd_stb <= 1'b0; cmd_op <= '0;
      wr_valid <= 1'b0; wr_data <= '0; proto_err <= 1'b0;
    end else begin
      cmd_stb   <= 1'b0;
      wr_valid  <= 1'b0;
      proto_err <= 1'b0;
      if (dly != '0) dly <= dly - 1'b1;
      if (!in_pay) begin
        if (fall) begin
          sh <= {dt, sh[15:1]};
          if (cnt == 4'd5) begin
            cnt <= '0;
            if (op_def) begin
              cmd_stb <= 1'b1;
              cmd_op  <= op_nxt;
            end
            if (op_pay) begin
              in_pay <= 1'b1;
              pay_rd <= (op_nxt == 6'h04);
              dly    <= DW'(DLY_CYCLES);
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else begin
        if (rise) begin
          if (dly != '0) proto_err <= 1'b1;
          if (pay_rd) begin
            if (cnt == 4'd15) sdat_o <= 1'b0;
            else if (cnt != 4'd0) begin
              sdat_o <= sh[0];
              sh     <= {1'b0, sh[15:1]};
            end
          end
        end
        if (fall) begin
          cnt <= cnt + 1'b1;
          if (!pay_rd) sh <= {dt, sh[15:1]};
          if (pay_rd && cnt == 4'd0) begin
            sdat_oe <= 1'b1;
            sdat_o  <= 1'b0;
            sh      <= {2'b00, rd_data};
          end
          if (cnt == 4'd15) begin
            in_pay  <= 1'b0;
            cnt     <= '0;
            sdat_oe <= 1'b0;
            sdat_o  <= 1'b0;
            if (!pay_rd) begin
              wr_valid <= 1'b1;
              wr_data  <= sh[15:2];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/pgm_cmd_frontend_chk.sv
module pgm_cmd_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sdat_o,
  input logic       sdat_oe,
  input logic       cmd_stb,
  input logic [5:0] cmd_op,
  input logic       wr_valid,
  input logic       proto_err
);
  assert_stb_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  assert_defined_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (cmd_op inside {6'h00, 6'h02, 6'h04, 6'h06, 6'h08, 6'h09,
                                6'h0A, 6'h11, 6'h16, 6'h18}));

  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_no_oe_at_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !sdat_oe);

  assert_no_oe_at_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> !sdat_oe);

  assert_start_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> !sdat_o);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);
endmodule

bind pgm_cmd_frontend pgm_cmd_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
  .cmd_stb(cmd_stb), .cmd_op(cmd_op), .wr_valid(wr_valid), .proto_err(proto_err)
);

// File: tb/pgm_cmd_frontend_bench.sv
module pgm_cmd_frontend_bench;
  localparam int DLY = 20;
  localparam int H   = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic sdat_o, sdat_oe, cmd_stb, wr_valid, proto_err;
  logic [5:0] cmd_op;
  logic [13:0] rd_data = '0, wr_data;

  int checks = 0, fails = 0, cyc = 0;
  int stb_n = 0, wr_n = 0, err_n = 0;
  logic [5:0] last_op;
  logic [13:0] last_wr;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgm_cmd_frontend #(.DLY_CYCLES(DLY)) u_pgm_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .sdat_o(sdat_o),
    .sdat_oe(sdat_oe), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_data(wr_data), .proto_err(proto_err));

  always @(negedge clk) begin
    if (cmd_stb) begin stb_n++; last_op = cmd_op; end
    if (wr_valid) begin wr_n++; last_wr = wr_data; end
    if (proto_err) err_n++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_def(input logic [5:0] op);
    return op == 6'h00 || op == 6'h02 || op == 6'h04 || op == 6'h06 ||
           op == 6'h16 || op == 6'h08 || op == 6'h18 || op == 6'h0A ||
           op == 6'h09 || op == 6'h11;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic clk_bit(input logic b);
    sdat = b; sclk = 1'b1; wait_cyc(H);
    sclk = 1'b0; wait_cyc(H);
  endtask

  task automatic send_cmd(input logic [5:0] op, input int gap);
    for (int i = 0; i < 6; i++) clk_bit(op[i]);
    wait_cyc(gap);
  endtask

  task automatic write_word(input logic [13:0] w);
    clk_bit(1'b0);
    for (int i = 0; i < 14; i++) clk_bit(w[i]);
    clk_bit(1'b0);
    wait_cyc(4);
  endtask

  task automatic read_word(input logic [13:0] w);
    int bad_bits = 0, bad_oe = 0;
    sdat = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b1; wait_cyc(H - 1);
      @(negedge clk);
      if (k == 1) begin
        if (sdat_oe !== 1'b0) bad_oe++;
      end else begin
        if (sdat_oe !== 1'b1) bad_oe++;
        if (k <= 15 && sdat_o !== w[k-2]) bad_bits++;
        if (k == 16 && sdat_o !== 1'b0) bad_bits++;
      end
      @(posedge clk);
      sclk = 1'b0; wait_cyc(H);
    end
    wait_cyc(4);
    chk(bad_bits == 0, "R6 read bits", bad_bits, 0);
    chk(bad_oe == 0, "R5 oe window", bad_oe, 0);
    chk(sdat_oe == 1'b0, "R5 oe released", sdat_oe, 0);
  endtask

  task automatic do_op(input logic [5:0] op, input logic [13:0] w);
    int s0, w0, e0;
    s0 = stb_n; w0 = wr_n; e0 = err_n;
    if (op == 6'h04) rd_data = w;
    send_cmd(op, DLY + 10);
    if (is_def(op)) begin
      chk(stb_n == s0 + 1 && last_op == op, "R1 strobe", last_op, op);
    end else begin
      chk(stb_n == s0, "R2 undefined ignored", stb_n - s0, 0);
    end
    if (op == 6'h00 || op == 6'h02) begin
      write_word(w);
      chk(wr_n == w0 + 1 && last_wr == w, "R3 write word", last_wr, w);
    end else if (op == 6'h04) begin
      read_word(w);
      chk(wr_n == w0, "R4 no write on read", wr_n - w0, 0);
    end else begin
      chk(wr_n == w0 && sdat_oe == 1'b0, "R8 no payload", wr_n - w0, 0);
    end
    chk(err_n == e0, "R7 no error with gap", err_n - e0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [13:0] pats [6];
    int e0;
    pats[0] = 14'h0000; pats[1] = 14'h3FFF; pats[2] = 14'h2AAA;
    pats[3] = 14'h1555; pats[4] = 14'h0001; pats[5] = 14'h2000;
    wait_cyc(5);
    @(negedge clk);
    chk(sdat_oe == 0 && cmd_stb == 0 && wr_valid == 0 && proto_err == 0 && sdat_o == 0,
        "R9 reset outputs", {sdat_oe, cmd_stb, wr_valid, proto_err, sdat_o}, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    for (int op = 0; op < 64; op++)
      do_op(6'(op), 14'(op * 259 + 7));
    for (int p = 0; p < 6; p++) begin
      do_op(6'h02, pats[p]);
      do_op(6'h00, ~pats[p]);
      do_op(6'h04, pats[p]);
    end
    for (int b = 0; b < 14; b++) do_op(6'h04, 14'(1) << b);
    e0 = err_n;
    send_cmd(6'h02, 0);
    write_word(14'h1234);
    chk(err_n == e0 + 1, "R7 early clock flagged", err_n - e0, 1);
    chk(last_wr == 14'h1234, "R7 payload still framed", last_wr, 14'h1234);
    do_op(6'h16, '0);
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule